// File: doc/BRIEF.md
# Register-Pair Doubleword Load/Store Sequencer

This block carries out one 64-bit load or store for a 32-bit core. The 64-bit operand sits in an even/odd register pair. A decode stage hands over a command with these fields: direction, pair register number, base register number, base value and a signed 12-bit offset. The block adds the offset to the base to form the effective address, then checks the pair number and the address alignment. If both are legal, it issues two word transactions on a single-word memory port. Each word transaction is atomic on its own.

For a store, the block reads the two pair registers through a read port as each word is sent. For a load, it captures both returned words and then writes them to the pair, one register per cycle. It does not write anything until both reads have finished without error. The write order puts the base register last, so the base register never changes when a fault stops the sequence. The pair x0/x1 is handled as a unit:
- a load to x0 performs both reads and writes nothing;
- a store from x0 sends zeros and never reads x1.

The block ends every accepted command with a one-cycle completion pulse or a one-cycle trap pulse. The trap pulse carries a cause code.

Top module: `pairls_seq`

## Requirements
- R1: An odd pair register number produces a trap with cause 2 (illegal instruction) in the cycle after acceptance. No memory request is issued and no register is written.
- R2: The effective address is the base value plus the 12-bit offset sign-extended to 32 bits.
- R3: If the pair number is even and the effective address is not a multiple of 4, the block traps with cause 4 for a load or cause 6 for a store. The trap comes in the cycle after acceptance and before any memory request.
- R4: An effective address that is a multiple of 4, including every multiple of 8, never traps for misalignment. It gives exactly two requests: the first at the effective address and the second at the effective address plus 4. Both requests have all four byte strobes set.
- R5: The even register maps to bits 31:0 and to the word at the effective address. The odd register maps to bits 63:32 and to the word at the effective address plus 4. This holds for both loads and stores.
- R6: A load writes the pair only after both responses have arrived without error, using two consecutive write cycles. If the base register is the even register, the odd register is written first and the base register last. Otherwise the even register is written first.
- R7: A response with its error flag set gives a trap with cause 5 for a load or cause 7 for a store, and no further request is issued. The pair and base registers keep their values. For a store, a word that was already accepted before the fault stays in memory.
- R8: A load whose pair number is 0 issues both reads and writes no register. In particular, it never writes x0 or x1.
- R9: A store whose pair number is 0 writes zero to both words and never reads register 1.
- R10: Each accepted command gives exactly one single-cycle pulse, either done or trap, never both. Commands are accepted only while cmd_ready is high.
- R11: While a memory request is waiting for ready, its valid, address and write enable stay unchanged.
- R12: After reset the block is idle: cmd_ready is high, and there is no request, no register write and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command is accepted |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_data_idx | input | 5 | Pair register number (must be even) |
| cmd_base_idx | input | 5 | Base register number |
| cmd_base_val | input | 32 | Base register value |
| cmd_offset | input | 12 | Signed address offset |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Store data |
| mem_req_we | output | 1 | Write request |
| mem_req_be | output | 4 | Byte strobes |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 32 | Load data |
| mem_rsp_err | input | 1 | Access fault on this word |
| rf_re | output | 1 | Register read strobe |
| rf_raddr | output | 5 | Register read number |
| rf_rdata | input | 32 | Register read data |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Register write number |
| rf_wdata | output | 32 | Register write data |
| done | output | 1 | Command completed (one cycle) |
| trap | output | 1 | Command trapped (one cycle) |
| trap_cause | output | 4 | Trap cause code |

## Verification
For a load, the last register write-back and the done pulse fall in the same cycle. Stores and loads to x0 pulse done straight from the final response instead. The bench covers all three endings by sweeping every offset alignment, several base and pair placements, and both directions. It checks the order of the logged write strobes against the count of done cycles, which must be exactly one. The same sweep injects a fault on the first word and on the second word, and judges the partial store and the untouched base register against memory and register models computed in the bench.

// File: rtl/pairls_pkg.sv
package pairls_pkg;
  parameter int CAUSE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ0, ST_RSP0, ST_REQ1, ST_RSP1, ST_WB0, ST_WB1
  } seq_state_e;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_MIS  = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_LD_FLT  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MIS  = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_FLT  = 4'd7;
endpackage

// File: rtl/pairls_agu.sv
module pairls_agu #(
  parameter int XW = 32,
  parameter int IW = 12,
  parameter int RW = 5
) (
  input  logic [XW-1:0] base_val,
  input  logic [IW-1:0] offset,
  input  logic [RW-1:0] data_idx,
  output logic [XW-1:0] ea,
  output logic          odd_reg,
  output logic          misal
);
  localparam int BW = XW / 8;
  localparam int AL = $clog2(BW);

  logic [XW-1:0] off_ext;

  always_comb begin
    off_ext = {{(XW-IW){offset[IW-1]}}, offset};
    ea      = base_val + off_ext;
    odd_reg = data_idx[0];
    misal   = |ea[AL-1:0];
  end
endmodule

// File: rtl/pairls_ctrl.sv
module pairls_ctrl
  import pairls_pkg::*;
#(
  parameter int XW = 32,
  parameter int RW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_store,
  input  logic [RW-1:0]      cmd_data_idx,
  input  logic [RW-1:0]      cmd_base_idx,
  input  logic [XW-1:0]      ea,
  input  logic               odd_reg,
  input  logic               misal,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XW-1:0]      mem_req_addr,
  output logic [XW-1:0]      mem_req_wdata,
  output logic               mem_req_we,
  output logic [XW/8-1:0]    mem_req_be,
  input  logic               mem_rsp_valid,
  input  logic [XW-1:0]      mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               rf_re,
  output logic [RW-1:0]      rf_raddr,
  input  logic [XW-1:0]      rf_rdata,
  output logic               rf_we,
  output logic [RW-1:0]      rf_waddr,
  output logic [XW-1:0]      rf_wdata,
  output logic               done,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause
);
  localparam int BW = XW / 8;
  localparam logic [XW-1:0] STEP = XW'(BW);

  seq_state_e         st_q, st_d;
  logic               done_q, done_d, trap_q, trap_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               store_q, swap_q;
  logic [RW-1:0]      didx_q;
  logic [XW-1:0]      ea_q, lo_q, hi_q;
  logic               acc_en, lo_en, hi_en, pair_zero, word_sel, wr_hi;

  assign acc_en    = cmd_valid && (st_q == ST_IDLE);
  assign pair_zero = (didx_q == '0);

  // next-state process
  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    cause_d = cause_q;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid) begin
        if (odd_reg) begin
          trap_d  = 1'b1;
          cause_d = CAUSE_ILLEGAL;
        end else if (misal) begin
          trap_d  = 1'b1;
          cause_d = cmd_store ? CAUSE_ST_MIS : CAUSE_LD_MIS;
        end else begin
          st_d = ST_REQ0;
        end
      end
      ST_REQ0: if (mem_req_ready) st_d = ST_RSP0;
      ST_REQ1: if (mem_req_ready) st_d = ST_RSP1;
      ST_RSP0: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          trap_d  = 1'b1;
          cause_d = store_q ? CAUSE_ST_FLT : CAUSE_LD_FLT;
          st_d    = ST_IDLE;
        end else begin
          lo_en = 1'b1;
          st_d  = ST_REQ1;
        end
      end
      ST_RSP1: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          trap_d  = 1'b1;
          cause_d = store_q ? CAUSE_ST_FLT : CAUSE_LD_FLT;
          st_d    = ST_IDLE;
        end else begin
          hi_en = 1'b1;
          if (store_q || pair_zero) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_WB0;
          end
        end
      end
      ST_WB0:  st_d = ST_WB1;
      ST_WB1:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      trap_q <= trap_d;
      if (trap_d) cause_q <= cause_d;
    end
  end

  // datapath registers, enabled
  always_ff @(posedge clk) begin
    if (acc_en) begin
      store_q <= cmd_store;
      didx_q  <= cmd_data_idx;
      swap_q  <= (cmd_base_idx == cmd_data_idx);
      ea_q    <= ea;
    end
    if (lo_en) lo_q <= mem_rsp_data;
    if (hi_en) hi_q <= mem_rsp_data;
  end

  // outputs
  always_comb begin
    word_sel      = (st_q == ST_REQ1);
    mem_req_valid = (st_q == ST_REQ0) || word_sel;
    mem_req_addr  = word_sel ? (ea_q + STEP) : ea_q;
    mem_req_we    = store_q;
    mem_req_be    = '1;
    rf_re         = mem_req_valid && store_q && !pair_zero;
    rf_raddr      = {didx_q[RW-1:1], word_sel};
    mem_req_wdata = pair_zero ? '0 : rf_rdata;
    wr_hi         = ((st_q == ST_WB0) == swap_q);
    rf_we         = (st_q == ST_WB0) || (st_q == ST_WB1);
    rf_waddr      = {didx_q[RW-1:1], wr_hi};
    rf_wdata      = wr_hi ? hi_q : lo_q;
    done          = done_q || (st_q == ST_WB1);
    trap          = trap_q;
    trap_cause    = cause_q;
    cmd_ready     = (st_q == ST_IDLE);
  end
endmodule

// File: rtl/pairls_seq.sv
module pairls_seq
  import pairls_pkg::*;
#(
  parameter int XW = 32,
  parameter int RW = 5,
  parameter int IW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_store,
  input  logic [RW-1:0]      cmd_data_idx,
  input  logic [RW-1:0]      cmd_base_idx,
  input  logic [XW-1:0]      cmd_base_val,
  input  logic [IW-1:0]      cmd_offset,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [XW-1:0]      mem_req_addr,
  output logic [XW-1:0]      mem_req_wdata,
  output logic               mem_req_we,
  output logic [XW/8-1:0]    mem_req_be,
  input  logic               mem_rsp_valid,
  input  logic [XW-1:0]      mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               rf_re,
  output logic [RW-1:0]      rf_raddr,
  input  logic [XW-1:0]      rf_rdata,
  output logic               rf_we,
  output logic [RW-1:0]      rf_waddr,
  output logic [XW-1:0]      rf_wdata,
  output logic               done,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause
);
  logic [XW-1:0] ea;
  logic          odd_reg, misal;

  pairls_agu #(.XW(XW), .IW(IW), .RW(RW)) agu_i (
    .base_val (cmd_base_val),
    .offset   (cmd_offset),
    .data_idx (cmd_data_idx),
    .ea       (ea),
    .odd_reg  (odd_reg),
    .misal    (misal)
  );

  pairls_ctrl #(.XW(XW), .RW(RW)) ctrl_i (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_store, .cmd_data_idx,
    .cmd_base_idx, .ea, .odd_reg, .misal,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_wdata,
    .mem_req_we, .mem_req_be, .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err,
    .rf_re, .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata,
    .done, .trap, .trap_cause
  );
endmodule

// File: rtl/pairls_seq_chk.sv
module pairls_seq_chk #(
  parameter int XW = 32,
  parameter int RW = 5,
  parameter int IW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            cmd_store,
  input logic [RW-1:0]   cmd_data_idx,
  input logic [XW-1:0]   cmd_base_val,
  input logic [IW-1:0]   cmd_offset,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XW-1:0]   mem_req_addr,
  input logic            mem_req_we,
  input logic [XW/8-1:0] mem_req_be,
  input logic            rf_we,
  input logic [RW-1:0]   rf_waddr,
  input logic            done,
  input logic            trap,
  input logic [3:0]      trap_cause
);
  logic [XW-1:0] sum_addr;
  logic          take;
  assign sum_addr = cmd_base_val + {{(XW-IW){cmd_offset[IW-1]}}, cmd_offset};
  assign take     = cmd_valid && cmd_ready;

  // R1
  odd_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_data_idx[0] |=> trap && trap_cause == 4'd2);

  // R3
  misal_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cmd_data_idx[0] && (sum_addr[1:0] != 2'b00) |=>
      trap && !mem_req_valid && (trap_cause == ($past(cmd_store) ? 4'd6 : 4'd4)));

  // R4
  full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_be == '1);

  // R8
  no_low_pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr[RW-1:1] != '0);

  // R10
  no_done_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
endmodule

bind pairls_seq pairls_seq_chk #(.XW(XW), .RW(RW), .IW(IW)) chk_i (.*);

// File: tb/pairls_seq_tb.sv
`timescale 1ns/1ps
module pairls_seq_tb_top;
  localparam logic [31:0] BASE = 32'h0000_0020;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_store;
  logic [4:0]  cmd_data_idx, cmd_base_idx;
  logic [31:0] cmd_base_val;
  logic [11:0] cmd_offset;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        rf_re, rf_we;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        done, trap;
  logic [3:0]  trap_cause;

  logic [31:0] mem [16];
  logic [31:0] regs [32];
  logic [31:0] mem0 [16];
  logic [31:0] regs0 [32];
  logic [4:0]  wlog [4];
  logic [31:0] rlog [4];
  int          wcnt, rcnt, checks, bad, cyc;
  logic        x1_read, err_en, stall_en;
  int          err_word;
  logic [3:0]  stall_cnt;

  pairls_seq dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rf_rdata      = regs[rf_raddr];
  assign mem_req_ready = stall_en ? stall_cnt[0] : 1'b1;

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 4'd1;
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      if (wcnt < 4) wlog[wcnt] <= rf_waddr;
      wcnt <= wcnt + 1;
    end
    if (rf_re && rf_raddr == 5'd1) x1_read <= 1'b1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (rcnt < 4) rlog[rcnt] <= mem_req_addr;
      rcnt          <= rcnt + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= err_en && (rcnt == err_word);
      mem_rsp_data  <= mem[mem_req_addr[5:2]];
      if (mem_req_we && !(err_en && rcnt == err_word))
        mem[mem_req_addr[5:2]] <= mem_req_wdata;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic st, input int didx, input int bidx, input int off, input int errmode);
    logic [31:0] ea, lo_exp, hi_exp;
    int idx, n_done, n_trap, exp_req, exp_cause, tmo, tail;
    logic [3:0] cause_seen;
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'h5A00_0000 + i * 32'h0001_0203;
      mem0[i] = mem[i];
    end
    for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'h0 : (32'hC000_0000 | (i * 32'h0000_0111));
    regs[bidx] = BASE;
    for (int i = 0; i < 32; i++) regs0[i] = regs[i];
    ea  = BASE + off;
    idx = int'(ea[5:2]);
    wcnt = 0; rcnt = 0; x1_read = 1'b0;
    err_en = (errmode != 0); err_word = errmode - 1;
    cmd_store = st; cmd_data_idx = 5'(didx); cmd_base_idx = 5'(bidx);
    cmd_base_val = BASE; cmd_offset = 12'(off); cmd_valid = 1'b1;
    n_done = 0; n_trap = 0; cause_seen = '0; tmo = 0; tail = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (tail < 3 && tmo < 60) begin
      if (done) n_done++;
      if (trap) begin n_trap++; cause_seen = trap_cause; end
      if (n_done + n_trap > 0) tail++;
      tmo++;
      @(negedge clk);
    end
    chk(tmo < 60, "R10 command finished", tmo, 0);
    // expectations
    if (didx % 2 == 1) begin exp_cause = 2; exp_req = 0; end
    else if (ea[1:0] != 2'b00) begin exp_cause = st ? 6 : 4; exp_req = 0; end
    else if (errmode != 0) begin exp_cause = st ? 7 : 5; exp_req = errmode; end
    else begin exp_cause = 0; exp_req = 2; end
    chk(n_done + n_trap == 1, "R10 one pulse", n_done + n_trap, 1);
    if (exp_cause != 0) begin
      chk(n_trap == 1 && cause_seen == 4'(exp_cause), exp_cause == 2 ? "R1 illegal cause" :
          (exp_req == 0 ? "R3 misaligned cause" : "R7 fault cause"), cause_seen, exp_cause);
      chk(wcnt == 0, "R7 no register write on trap", wcnt, 0);
      chk(regs[bidx] == regs0[bidx], "R7 base intact", regs[bidx], regs0[bidx]);
    end else begin
      chk(n_done == 1, "R4 aligned completes", n_done, 1);
    end
    chk(rcnt == exp_req, exp_req == 0 ? "R3 no memory op" : "R4 request count", rcnt, exp_req);
    if (exp_req >= 1) chk(rlog[0] == ea, "R2 first word address", rlog[0], ea);
    if (exp_req == 2) chk(rlog[1] == ea + 4, "R4 second word address", rlog[1], ea + 4);
    if (st && exp_req > 0) begin
      lo_exp = (didx == 0) ? 32'h0 : regs0[didx];
      hi_exp = (didx == 0) ? 32'h0 : regs0[didx + 1];
      chk(!x1_read, "R9 x1 not read", x1_read, 0);
      if (errmode == 1) chk(mem[idx] == mem0[idx], "R7 faulted word untouched", mem[idx], mem0[idx]);
      else chk(mem[idx] == lo_exp, didx == 0 ? "R9 low zero" : "R5 low word stored", mem[idx], lo_exp);
      if (errmode == 0) chk(mem[idx + 1] == hi_exp, didx == 0 ? "R9 high zero" : "R5 high word stored", mem[idx + 1], hi_exp);
      else chk(mem[idx + 1] == mem0[idx + 1], "R7 second word untouched", mem[idx + 1], mem0[idx + 1]);
    end
    if (!st && exp_cause == 0) begin
      if (didx == 0) begin
        chk(wcnt == 0, "R8 no write for x0 load", wcnt, 0);
        chk(regs[1] == regs0[1], "R8 x1 unchanged", regs[1], regs0[1]);
      end else begin
        chk(wcnt == 2, "R6 two writes", wcnt, 2);
        chk(wlog[1] == 5'(bidx == didx ? didx : didx + 1), "R6 last write order", wlog[1],
            bidx == didx ? didx : didx + 1);
        chk(regs[didx] == mem0[idx], "R5 even reg low word", regs[didx], mem0[idx]);
        chk(regs[didx + 1] == mem0[idx + 1], "R5 odd reg high word", regs[didx + 1], mem0[idx + 1]);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int bidx, ncmd;
    checks = 0; bad = 0; cyc = 0; stall_cnt = '0; stall_en = 1'b0;
    wcnt = 0; rcnt = 0; x1_read = 1'b0; err_en = 1'b0; err_word = 0;
    cmd_valid = 1'b0; cmd_store = 1'b0; cmd_data_idx = '0; cmd_base_idx = '0;
    cmd_base_val = '0; cmd_offset = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R12 ready after reset", cmd_ready, 1);
    chk(!mem_req_valid && !rf_we, "R12 quiet after reset", {mem_req_valid, rf_we}, 0);
    chk(!done && !trap, "R12 no pulse after reset", {done, trap}, 0);
    ncmd = 0;
    for (int st = 0; st < 2; st++)
      for (int d = 0; d < 4; d++)
        for (int bs = 0; bs < 3; bs++)
          for (int off = -16; off < 16; off++)
            for (int em = 0; em < 3; em++) begin
              int didx;
              didx = (d == 0) ? 0 : (d == 1) ? 4 : (d == 2) ? 8 : 9;
              bidx = (bs == 0) ? 2 : (bs == 1) ? didx : didx + 1;
              if (bidx == 0) bidx = 3;
              if (em == 0 || (off & 3) == 0) begin
                stall_en = ncmd[0];
                ncmd++;
                run_cmd(st[0], didx, bidx, off, em);
              end
            end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule